// File: doc/BRIEF.md
# Audio DAC Soft-Reset Resynchronization Sequencer

This block sits in the digital core of an audio converter, between the register file and the sample datapath. A software run bit controls an internal core reset. The falling and rising edges of that reset are delayed by whole sample periods, counted on a once-per-sample strobe. Clearing the bit raises a zero-detect flag at once. The flag also serves as the resynchronization window, and it stays high until two sample periods after the core reset has been released.

While the window is open, a rising edge on the resync request produces a one-clock pulse that resets the sample counter downstream. The same pulse starts a run of forced-zero output samples. Zero data is also output for as long as the core reset holds the datapath in power-down. Samples pass through on a valid/ready stream without storage. Ready and valid propagate combinationally in both directions: back-pressure from the sink reaches the source in the same cycle, and a sample is transferred on any clock where both `s_valid` and `m_ready` are high.

Top module: `dac_resync_seq`

## Requirements
- R1: While the hardware reset `rst_n` is low, `core_rst_n` is 0, `zd_flag` is 0, `cnt_rst` is 0 and `m_data` is all zeros.
- R2: One clock after `run_bit` goes from 1 to 0, `zd_flag` is 1.
- R3: After `run_bit` falls, `core_rst_n` goes to 0 on the clock edge of the 4th `smp_stb` counted after the cycle in which the bit changed.
- R4: After `run_bit` rises, `core_rst_n` goes to 1 on the clock edge of the 3rd such strobe.
- R5: `zd_flag` falls on the edge of the 2nd strobe after the rise of `core_rst_n` completes.
- R6: When `resync_req` rises while `zd_flag` is 1, `cnt_rst` is 1 for exactly one clock, in the next clock. A request held high yields only one pulse.
- R7: When `resync_req` rises while `zd_flag` is 0, it produces no pulse and no zero run.
- R8: A `cnt_rst` pulse forces `m_data` to zero until the edge of the 5th strobe after the accepting cycle. A new pulse during a run restarts the full 5-strobe length.
- R9: `m_data` is zero while `core_rst_n` is 0. Otherwise, outside a zero run, it equals `s_data`.
- R10: A `run_bit` change made before the pending delayed edge has completed restarts the count toward the new level. The completion of a count toward 1 starts the flag tail even if `core_rst_n` never fell.
- R11: A resync request is accepted whenever `zd_flag` is 1, including before `core_rst_n` has fallen.
- R12: `m_valid` equals `s_valid` and `s_ready` equals `m_ready` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| smp_stb | input | 1 | One-clock strobe, once per sample period |
| run_bit | input | 1 | Software run bit; 0 requests core reset |
| resync_req | input | 1 | Counter resynchronization request (edge-detected) |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Input sample ready |
| s_data | input | DATA_W | Input sample word |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Output sample ready |
| m_data | output | DATA_W | Gated output sample word |
| core_rst_n | output | 1 | Delayed internal core reset, active low |
| zd_flag | output | 1 | Zero-detect flag / resync window |
| cnt_rst | output | 1 | One-clock sample-counter reset pulse |

## Verification
The main function is exercised with several patterns of bit writes. A clean fall/rise cycle fixes the exact strobe counts on each edge, in contrast to a reversed write before the count completes, which shows whether the count restarts or the stale edge lands. Resync requests are placed at three points: before the core reset falls, inside the two-strobe tail, and with the flag low. These separate acceptance by window from acceptance by reset state. A second request inside a zero run shows whether the run restarts or keeps its original end.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  // Level carried on the internal core reset line
  typedef enum logic {
    LVL_HELD = 1'b0,
    LVL_RUN  = 1'b1
  } rsq_lvl_t;

  function automatic int rsq_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rsq_timer.sv
module rsq_timer #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         stb,
  output logic         expire
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (load)                 cnt <= load_val;
    else if (stb && cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign expire = stb && !load && (cnt == W'(1));
endmodule

// File: rtl/rsq_delay.sv
module rsq_delay
  import rsq_pkg::*;
#(
  parameter int W        = 3,
  parameter int FALL_STB = 4,
  parameter int RISE_STB = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic run_bit,
  output logic core_rst_n,
  output logic fall_edge,
  output logic rise_done
);
  localparam logic [W-1:0] FALL_V = W'(FALL_STB);
  localparam logic [W-1:0] RISE_V = W'(RISE_STB);

  logic     run_q;
  rsq_lvl_t tgt;
  rsq_lvl_t core_lvl;
  logic     bit_edge;
  logic     tmr_exp;

  assign bit_edge  = run_q ^ run_bit;
  assign fall_edge = run_q & ~run_bit;

  rsq_timer #(.W(W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (bit_edge),
    .load_val (run_bit ? RISE_V : FALL_V),
    .stb      (stb),
    .expire   (tmr_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      tgt      <= LVL_HELD;
      core_lvl <= LVL_HELD;
    end else begin
      run_q <= run_bit;
      if (bit_edge) tgt      <= run_bit ? LVL_RUN : LVL_HELD;
      if (tmr_exp)  core_lvl <= tgt;
    end
  end

  assign core_rst_n = (core_lvl == LVL_RUN);
  assign rise_done  = tmr_exp && (tgt == LVL_RUN);

  // R3
  core_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(core_rst_n) |-> $past(stb));
endmodule

// File: rtl/rsq_window.sv
module rsq_window #(
  parameter int W        = 3,
  parameter int TAIL_STB = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic fall_edge,
  input  logic rise_done,
  input  logic resync_req,
  output logic flag,
  output logic cnt_rst,
  output logic accept
);
  localparam logic [W-1:0] TAIL_V = W'(TAIL_STB);

  logic req_q;
  logic tail_exp;

  rsq_timer #(.W(W)) u_tail (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (fall_edge | rise_done),
    .load_val (fall_edge ? '0 : TAIL_V),
    .stb      (stb),
    .expire   (tail_exp)
  );

  assign accept = resync_req & ~req_q & flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      req_q   <= 1'b0;
      cnt_rst <= 1'b0;
    end else begin
      req_q   <= resync_req;
      cnt_rst <= accept;
      if (fall_edge)     flag <= 1'b1;
      else if (tail_exp) flag <= 1'b0;
    end
  end

  // R6
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst |=> !cnt_rst);
  // R7
  win_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst |-> $past(flag));
endmodule

// File: rtl/rsq_gate.sv
module rsq_gate #(
  parameter int W        = 3,
  parameter int DATA_W   = 24,
  parameter int ZERO_STB = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic              accept,
  input  logic              core_rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data
);
  localparam logic [W-1:0] ZERO_V = W'(ZERO_STB);

  logic zero_on;
  logic z_exp;

  rsq_timer #(.W(W)) u_zero (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (ZERO_V),
    .stb      (stb),
    .expire   (z_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      zero_on <= 1'b0;
    else if (accept) zero_on <= 1'b1;
    else if (z_exp)  zero_on <= 1'b0;
  end

  assign m_valid = s_valid;
  assign s_ready = m_ready;
  assign m_data  = (core_rst_n && !zero_on) ? s_data : '0;

  // R9
  held_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_rst_n |-> (m_data == '0));
endmodule

// File: rtl/dac_resync_seq.sv
module dac_resync_seq
  import rsq_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int FALL_STB = 4,
  parameter int RISE_STB = 3,
  parameter int TAIL_STB = 2,
  parameter int ZERO_STB = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_stb,
  input  logic              run_bit,
  input  logic              resync_req,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              core_rst_n,
  output logic              zd_flag,
  output logic              cnt_rst
);
  localparam int MAXV  = rsq_max(rsq_max(FALL_STB, RISE_STB), rsq_max(TAIL_STB, ZERO_STB));
  localparam int CNT_W = $clog2(MAXV + 1);

  logic fall_edge;
  logic rise_done;
  logic accept;

  rsq_delay #(.W(CNT_W), .FALL_STB(FALL_STB), .RISE_STB(RISE_STB)) u_delay (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (smp_stb),
    .run_bit    (run_bit),
    .core_rst_n (core_rst_n),
    .fall_edge  (fall_edge),
    .rise_done  (rise_done)
  );

  rsq_window #(.W(CNT_W), .TAIL_STB(TAIL_STB)) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (smp_stb),
    .fall_edge  (fall_edge),
    .rise_done  (rise_done),
    .resync_req (resync_req),
    .flag       (zd_flag),
    .cnt_rst    (cnt_rst),
    .accept     (accept)
  );

  rsq_gate #(.W(CNT_W), .DATA_W(DATA_W), .ZERO_STB(ZERO_STB)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (smp_stb),
    .accept     (accept),
    .core_rst_n (core_rst_n),
    .s_valid    (s_valid),
    .s_ready    (s_ready),
    .s_data     (s_data),
    .m_valid    (m_valid),
    .m_ready    (m_ready),
    .m_data     (m_data)
  );

  // R2
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zd_flag) |-> !$past(run_bit));
  // R5
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(zd_flag) |-> (core_rst_n && $past(smp_stb)));
  // R8
  zero_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst |-> (m_data == '0));
endmodule

// File: tb/dac_resync_seq_tb.sv
module dac_resync_seq_tb;
  localparam int DW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_stb = 1'b0;
  logic          run_bit = 1'b0;
  logic          resync_req = 1'b0;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [DW-1:0] s_data = '0;
  logic          m_valid;
  logic          m_ready = 1'b0;
  logic [DW-1:0] m_data;
  logic          core_rst_n;
  logic          zd_flag;
  logic          cnt_rst;

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always #5 clk = ~clk;

  dac_resync_seq #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .run_bit(run_bit),
    .resync_req(resync_req), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .core_rst_n(core_rst_n), .zd_flag(zd_flag), .cnt_rst(cnt_rst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock; strobe optionally asserted for that edge
  task automatic cyc(input logic s);
    smp_stb = s;
    @(posedge clk); #1;
    smp_stb = 1'b0;
  endtask

  // driver: push expected output, present one sample for one clock
  task automatic send(input logic [DW-1:0] d, input logic [DW-1:0] e, input string req);
    s_data  = d;
    s_valid = 1'b1;
    m_ready = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(req);
    cyc(1'b0);
    s_valid = 1'b0;
  endtask

  // monitor: compare each transferred sample against the scoreboard
  always @(negedge clk) begin
    if (s_valid && m_ready) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9 actual=%0h expected=none", m_data);
      end else begin
        automatic logic [DW-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, 32'(m_data), 32'(e));
      end
    end
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    s_data = 24'hFFFFFF; s_valid = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", 32'(core_rst_n), 0);
    chk("R1", 32'(zd_flag), 0);
    chk("R1", 32'(cnt_rst), 0);
    chk("R1", 32'(m_data), 0);
    s_valid = 1'b0;
    rst_n = 1'b1;
    cyc(1'b0);

    // R4: bring-up rise after 3 strobes
    run_bit = 1'b1;
    cyc(1'b0);
    cyc(1'b1); cyc(1'b1);
    chk("R4", 32'(core_rst_n), 0);
    cyc(1'b1);
    chk("R4", 32'(core_rst_n), 1);
    chk("R5", 32'(zd_flag), 0);
    cyc(1'b1); cyc(1'b1);
    send(24'h5A5A5A, 24'h5A5A5A, "R9");

    // R2, R11, R6, R8, R3
    run_bit = 1'b0;
    cyc(1'b0);
    chk("R2", 32'(zd_flag), 1);
    resync_req = 1'b1;
    cyc(1'b0);
    chk("R11", 32'(cnt_rst), 1);
    chk("R11", 32'(core_rst_n), 1);
    cyc(1'b0);
    chk("R6", 32'(cnt_rst), 0);
    send(24'h000ABC, 24'h0, "R8");
    cyc(1'b1); cyc(1'b1); cyc(1'b1);
    chk("R3", 32'(core_rst_n), 1);
    cyc(1'b1);
    chk("R3", 32'(core_rst_n), 0);
    chk("R6", 32'(cnt_rst), 0);
    cyc(1'b1); cyc(1'b1);
    resync_req = 1'b0;
    send(24'h123456, 24'h0, "R9");

    // R4, R5, R8 restart inside the tail window
    run_bit = 1'b1;
    cyc(1'b0);
    cyc(1'b1); cyc(1'b1);
    chk("R4", 32'(core_rst_n), 0);
    cyc(1'b1);
    chk("R4", 32'(core_rst_n), 1);
    chk("R5", 32'(zd_flag), 1);
    resync_req = 1'b1;
    cyc(1'b0);
    chk("R8", 32'(cnt_rst), 1);
    cyc(1'b1);
    chk("R5", 32'(zd_flag), 1);
    resync_req = 1'b0;
    cyc(1'b0);
    resync_req = 1'b1;
    cyc(1'b0);
    chk("R8", 32'(cnt_rst), 1);
    cyc(1'b1);
    chk("R5", 32'(zd_flag), 0);
    cyc(1'b1); cyc(1'b1); cyc(1'b1);
    send(24'h00BEEF, 24'h0, "R8");
    cyc(1'b1);
    send(24'h00BEEF, 24'h00BEEF, "R8");
    resync_req = 1'b0;

    // R7: request with flag low is ignored
    cyc(1'b0);
    resync_req = 1'b1;
    cyc(1'b0);
    chk("R7", 32'(cnt_rst), 0);
    cyc(1'b0);
    chk("R7", 32'(cnt_rst), 0);
    send(24'hC0FFEE, 24'hC0FFEE, "R7");
    resync_req = 1'b0;

    // R10: reversed write before the fall completes
    run_bit = 1'b0;
    cyc(1'b0);
    chk("R10", 32'(zd_flag), 1);
    cyc(1'b1); cyc(1'b1);
    run_bit = 1'b1;
    cyc(1'b0);
    cyc(1'b1); cyc(1'b1);
    chk("R10", 32'(core_rst_n), 1);
    cyc(1'b1);
    chk("R10", 32'(zd_flag), 1);
    cyc(1'b1);
    chk("R10", 32'(zd_flag), 1);
    cyc(1'b1);
    chk("R10", 32'(zd_flag), 0);
    chk("R10", 32'(core_rst_n), 1);

    // R12: stream pass-through
    s_valid = 1'b1; m_ready = 1'b0;
    #1;
    chk("R12", 32'(m_valid), 1);
    chk("R12", 32'(s_ready), 0);
    s_valid = 1'b0; m_ready = 1'b1;
    #1;
    chk("R12", 32'(m_valid), 0);
    chk("R12", 32'(s_ready), 1);
    m_ready = 1'b0;
    cyc(1'b0);

    chk("R9", 32'(exp_q.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule